// File: doc/BRIEF.md
# Supply Supervisor with Watchdog

This block is the reset controller of a microcontroller system. It runs on a free-running system clock and combines three reasons to hold the system in reset. The first is a supply-good flag from an external comparator, already synchronous to the clock. The second is a manual request, read back from the shared active-low reset line. The third is a watchdog that expires when its kick input stops changing. Every reset reason ends in the same stretch: the outputs release only after a fixed number of quiet clock cycles.

Both outputs are open-drain pull-low enables. External pull resistors set the released level of each line. The active-low line is pulled low while reset is in effect. The active-high line is pulled low only while reset is not in effect, so its pull-up raises it during reset. A loss of supply reaches both enables in the same cycle, through a path with no register in it. The block reads back the active-low line it drives, and it masks its own drive for the length of the synchronizer, so its own pull-down is never taken as a manual request.

All time constants are parameters in clock cycles. A parameter removes the watchdog. The system reset input `rstN` puts the block into the power-on stretch.

Top module: `supplySupervisor`

## Requirements
- R1: While `supplyGood` is 0, `rstLowPullEn` is 1 and `rstHighPullEn` is 0 in that same cycle, with no clock edge in between.
- R2: The outputs release exactly STRETCH_CYCLES clock edges after the last edge at which a reset reason was present, provided no new reason appears meanwhile.
- R3: After `rstN` is deasserted with every other input quiet, the reset is in effect for exactly STRETCH_CYCLES edges and then releases.
- R4: With WD_ENABLE=1, if WD_CYCLES edges pass after a release without a level change on `wdKick` (after synchronization), a reset followed by a full stretch starts.
- R5: A 0-to-1 change and a 1-to-0 change on `wdKick` both restart the watchdog count. A steady 0 or a steady 1 does not restart it.
- R6: A low level on `resetLineIn` that the block is not causing is taken as a manual request SYNC_STAGES+1 edges after it appears. The stretch restarts for as long as the request is seen.
- R7: The block's own pull-down on the reset line, including the synchronizer delay after it lets go, is never taken as a manual request. A reset with no outside pull ends after one stretch and does not re-trigger.
- R8: `rstHighPullEn` is always the inverse of `rstLowPullEn`. Both come from one reset state.
- R9: The watchdog count is held at zero while reset is in effect. Kicks during reset have no effect, and the next timeout comes WD_CYCLES edges after the release.
- R10: With WD_ENABLE=0, no amount of quiet on `wdKick` produces a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low system reset; starts the power-on stretch |
| supplyGood | input | 1 | Synchronous supply-within-tolerance flag; 0 forces reset at once |
| resetLineIn | input | 1 | Level read back from the active-low reset line (asynchronous) |
| wdKick | input | 1 | Watchdog kick; any level change restarts the watchdog (asynchronous) |
| rstLowPullEn | output | 1 | Pull-down enable of the active-low reset line; 1 while reset is in effect |
| rstHighPullEn | output | 1 | Pull-down enable of the active-high reset line; 1 while reset is not in effect |

## Verification
If the stretch counter is wrong, the release edge of `rstLowPullEn` moves by at least one cycle. The cycle-by-cycle comparison catches this at the first cycle after the expected release. If the readback mask is too short, the block re-enters reset a few cycles after every release of its own reset. If the mask is too long, an outside pull starts reset late. Both faults show within SYNC_STAGES+1 cycles. If the watchdog count is wrong, or it ignores one edge direction, a reset appears or goes missing one WD_CYCLES window after the last kick.

// File: rtl/supSupervisorPkg.sv
package supSupervisorPkg;

  // Strobes from the control to the datapath counters.
  typedef struct packed {
    logic stretchClear;
    logic stretchInc;
    logic wdClear;
    logic wdInc;
  } supStrobes_t;

endpackage

// File: rtl/supSync.sv
module supSync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= RESET_VAL;
          else       chain[g] <= asyncIn;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= RESET_VAL;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/supDatapath.sv
module supDatapath
  import supSupervisorPkg::*;
#(
  parameter int STRETCH_CYCLES = 200,
  parameter int WD_CYCLES      = 1600,
  parameter bit WD_ENABLE      = 1'b1,
  parameter int SYNC_STAGES    = 2,
  localparam int STRETCH_W     = $clog2(STRETCH_CYCLES + 1),
  localparam int WD_W          = $clog2(WD_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            resetLineIn,
  input  logic            wdKick,
  input  logic            drive,
  input  supStrobes_t     strobes,
  output logic            manualReq,
  output logic            kickEdge,
  output logic            stretchDone,
  output logic            wdExpired,
  output logic [WD_W-1:0] wdCount
);

  localparam logic [STRETCH_W-1:0] STRETCH_LAST = STRETCH_W'(STRETCH_CYCLES - 1);
  localparam logic [WD_W-1:0]      WD_LAST      = WD_W'(WD_CYCLES - 1);

  logic                   lineSync;
  logic                   kickSync;
  logic                   kickPrev;
  logic [SYNC_STAGES-1:0] driveHist;
  logic [STRETCH_W-1:0]   stretchCount;

  supSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_lineSync (
    .clk(clk), .rstN(rstN), .asyncIn(resetLineIn), .syncOut(lineSync)
  );

  supSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_kickSync (
    .clk(clk), .rstN(rstN), .asyncIn(wdKick), .syncOut(kickSync)
  );

  // The history of our own drive, one entry per synchronizer stage.
  // The line level seen now was sampled while the oldest entry was driving.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveHist <= '1;
      kickPrev  <= 1'b0;
    end else begin
      driveHist[0] <= drive;
      for (int i = 1; i < SYNC_STAGES; i++) driveHist[i] <= driveHist[i-1];
      kickPrev <= kickSync;
    end
  end

  assign manualReq = !lineSync && !(|driveHist);
  assign kickEdge  = kickSync ^ kickPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     stretchCount <= '0;
    else if (strobes.stretchClear) stretchCount <= '0;
    else if (strobes.stretchInc)   stretchCount <= stretchCount + 1'b1;
  end

  assign stretchDone = (stretchCount == STRETCH_LAST);

  generate
    if (WD_ENABLE) begin : gWatchdog
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                wdCount <= '0;
        else if (strobes.wdClear) wdCount <= '0;
        else if (strobes.wdInc && wdCount != WD_LAST) wdCount <= wdCount + 1'b1;
      end
      assign wdExpired = (wdCount == WD_LAST) && !kickEdge;
    end else begin : gNoWatchdog
      assign wdCount   = '0;
      assign wdExpired = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/supControl.sv
module supControl
  import supSupervisorPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyGood,
  input  logic        manualReq,
  input  logic        wdExpired,
  input  logic        kickEdge,
  input  logic        stretchDone,
  output supStrobes_t strobes,
  output logic        drive
);

  logic rstActive;
  logic cause;

  assign cause = !supplyGood || manualReq || wdExpired;
  assign drive = rstActive || !supplyGood;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     rstActive <= 1'b1;
    else if (cause)                rstActive <= 1'b1;
    else if (rstActive && stretchDone) rstActive <= 1'b0;
  end

  always_comb begin
    strobes              = '0;
    strobes.stretchClear = cause;
    strobes.stretchInc   = !cause && rstActive && !stretchDone;
    strobes.wdClear      = drive || kickEdge;
    strobes.wdInc        = !strobes.wdClear;
  end

endmodule

// File: rtl/supplySupervisor.sv
module supplySupervisor
  import supSupervisorPkg::*;
#(
  parameter int STRETCH_CYCLES = 200,
  parameter int WD_CYCLES      = 1600,
  parameter bit WD_ENABLE      = 1'b1,
  parameter int SYNC_STAGES    = 2,
  localparam int WD_W          = $clog2(WD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyGood,
  input  logic resetLineIn,
  input  logic wdKick,
  output logic rstLowPullEn,
  output logic rstHighPullEn
);

  supStrobes_t     strobes;
  logic            drive;
  logic            manualReq;
  logic            kickEdge;
  logic            stretchDone;
  logic            wdExpired;
  logic [WD_W-1:0] wdCount;

  supControl i_control (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .manualReq(manualReq),
    .wdExpired(wdExpired), .kickEdge(kickEdge), .stretchDone(stretchDone),
    .strobes(strobes), .drive(drive)
  );

  supDatapath #(
    .STRETCH_CYCLES(STRETCH_CYCLES), .WD_CYCLES(WD_CYCLES),
    .WD_ENABLE(WD_ENABLE), .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .resetLineIn(resetLineIn), .wdKick(wdKick),
    .drive(drive), .strobes(strobes), .manualReq(manualReq),
    .kickEdge(kickEdge), .stretchDone(stretchDone), .wdExpired(wdExpired),
    .wdCount(wdCount)
  );

  assign rstLowPullEn  = drive;
  assign rstHighPullEn = !drive;

endmodule

// File: rtl/supplySupervisorChk.sv
module supplySupervisorChk
  import supSupervisorPkg::*;
#(
  parameter int STRETCH_CYCLES = 200,
  parameter int WD_CYCLES      = 1600,
  parameter bit WD_ENABLE      = 1'b1,
  localparam int WD_W          = $clog2(WD_CYCLES + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            supplyGood,
  input logic            rstLowPullEn,
  input logic            rstHighPullEn,
  input logic            kickEdge,
  input logic [WD_W-1:0] wdCount,
  input supStrobes_t     strobes
);

  int holdRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdRun <= 0;
    else if (rstLowPullEn) holdRun <= holdRun + 1;
    else                   holdRun <= 0;
  end

  assert_supply_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |-> rstLowPullEn);

  assert_release_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstLowPullEn) |-> supplyGood && $past(supplyGood));

  assert_stretch_length_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstLowPullEn) |-> holdRun >= STRETCH_CYCLES - 1);

  assert_wd_timeout_R4: assert property (@(posedge clk) disable iff (!rstN)
    (WD_ENABLE && wdCount == WD_W'(WD_CYCLES - 1) && !kickEdge) |=> rstLowPullEn);

  assert_polarity_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstHighPullEn != rstLowPullEn);

  assert_wd_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstLowPullEn |=> wdCount == '0);

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.stretchClear, strobes.stretchInc}));

endmodule

bind supplySupervisor supplySupervisorChk #(
  .STRETCH_CYCLES(STRETCH_CYCLES), .WD_CYCLES(WD_CYCLES), .WD_ENABLE(WD_ENABLE)
) i_chk (
  .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .rstLowPullEn(rstLowPullEn),
  .rstHighPullEn(rstHighPullEn), .kickEdge(kickEdge), .wdCount(wdCount),
  .strobes(strobes)
);

// File: tb/test_supplySupervisor.sv
module test_supplySupervisor;

  localparam int CLK_PERIOD = 10;
  localparam int STRETCH    = 20;
  localparam int WDC        = 50;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b1;
  logic wdKick = 1'b0;
  logic extPull = 1'b0;
  logic kickOn = 1'b0;
  logic rstLowPullEn, rstHighPullEn;
  logic lowNoWd, highNoWd;
  logic resetLine, resetLineNoWd;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string tag = "R3";

  assign resetLine     = !(rstLowPullEn || extPull);
  assign resetLineNoWd = !(lowNoWd || extPull);

  always #(CLK_PERIOD/2) clk = !clk;

  supplySupervisor #(.STRETCH_CYCLES(STRETCH), .WD_CYCLES(WDC), .WD_ENABLE(1'b1),
                     .SYNC_STAGES(SYNC)) i_supplySupervisor (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .resetLineIn(resetLine),
    .wdKick(wdKick), .rstLowPullEn(rstLowPullEn), .rstHighPullEn(rstHighPullEn)
  );

  supplySupervisor #(.STRETCH_CYCLES(STRETCH), .WD_CYCLES(WDC), .WD_ENABLE(1'b0),
                     .SYNC_STAGES(SYNC)) i_supplySupervisorNoWd (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .resetLineIn(resetLineNoWd),
    .wdKick(wdKick), .rstLowPullEn(lowNoWd), .rstHighPullEn(highNoWd)
  );

  // Behavioural reference: integers for time since last reason and since last kick,
  // queues for the delayed views of the line and the kick input.
  bit mActive;
  int sinceCause;
  int quiet;
  bit lineQ[$];
  bit kickQ[$];
  bit driveQ[$];
  bit lastKickSeen;

  task automatic modelInit();
    mActive = 1; sinceCause = 0; quiet = 0; lastKickSeen = 0;
    lineQ.delete(); kickQ.delete(); driveQ.delete();
    for (int i = 0; i < SYNC; i++) begin
      lineQ.push_back(1'b1); kickQ.push_back(1'b0); driveQ.push_back(1'b1);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) modelInit();
    else begin
      bit drv, lineSeen, kickSeen, ownMask, manual, kedge, wdTo, cause;
      drv = mActive || !supplyGood;
      lineSeen = lineQ[0];
      kickSeen = kickQ[0];
      ownMask = 0;
      foreach (driveQ[i]) ownMask |= driveQ[i];
      manual = !lineSeen && !ownMask;
      kedge = kickSeen != lastKickSeen;
      wdTo = (quiet >= WDC - 1) && !kedge;
      cause = !supplyGood || manual || wdTo;
      if (cause) begin mActive = 1; sinceCause = 0; end
      else if (mActive) begin
        sinceCause++;
        if (sinceCause >= STRETCH) mActive = 0;
      end
      if (drv || kedge) quiet = 0; else quiet++;
      lastKickSeen = kickSeen;
      void'(lineQ.pop_front());  lineQ.push_back(!(drv || extPull));
      void'(kickQ.pop_front());  kickQ.push_back(wdKick);
      void'(driveQ.pop_front()); driveQ.push_back(drv);
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      bit expLow;
      expLow = mActive || !supplyGood;
      check(tag, rstLowPullEn, expLow);
      check("R8", rstHighPullEn, !expLow);
    end
  end

  // Background kicker: toggles the kick input every 16 cycles when enabled.
  initial begin
    forever begin
      repeat (16) @(negedge clk);
      #1;
      if (kickOn) wdKick = !wdKick;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 20000) begin @(posedge clk); wd++; end
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    step(3);
    rstN = 1'b1;
    // R3: power-on stretch; released after exactly STRETCH edges.
    tag = "R3";
    step(0);
    check("R3", rstLowPullEn, 1'b1);
    repeat (STRETCH - 1) @(posedge clk);
    @(negedge clk);
    check("R3", rstLowPullEn, 1'b1);
    @(negedge clk);
    check("R3", rstLowPullEn, 1'b0);
    #1;

    // R5: kicks from both edge directions keep the watchdog away.
    tag = "R5";
    kickOn = 1'b1;
    step(200);
    check("R5", rstLowPullEn, 1'b0);

    // R4 / R10: steady level, the watchdog fires; the no-watchdog instance stays released.
    tag = "R4";
    kickOn = 1'b0;
    step(150);
    check("R10", lowNoWd, 1'b0);
    wdKick = 1'b1;
    step(130);
    check("R10", lowNoWd, 1'b0);

    // R9: kicks during reset do nothing; timeout counted from release.
    tag = "R9";
    for (int i = 0; i < 10; i++) begin
      step(3);
      wdKick = !wdKick;
    end
    step(150);

    // R1 / R2: supply loss, immediate assertion, stretched release.
    tag = "R2";
    kickOn = 1'b1;
    step(80);
    supplyGood = 1'b0;
    #1;
    check("R1", rstLowPullEn, 1'b1);
    check("R1", rstHighPullEn, 1'b0);
    step(5);
    supplyGood = 1'b1;
    step(STRETCH + 10);
    // single-cycle glitch
    supplyGood = 1'b0;
    #1;
    check("R1", rstLowPullEn, 1'b1);
    step(1);
    supplyGood = 1'b1;
    step(STRETCH + 5);

    // R7: after a self-caused reset ends, no re-trigger from our own drive.
    tag = "R7";
    step(15);
    check("R7", rstLowPullEn, 1'b0);

    // R6: short outside pull, then a long hold.
    tag = "R6";
    extPull = 1'b1;
    step(3);
    extPull = 1'b0;
    step(STRETCH + 10);
    extPull = 1'b1;
    step(70);
    extPull = 1'b0;
    step(STRETCH + 10);
    check("R6", rstLowPullEn, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule